// File: doc/BRIEF.md
# Return and interrupt-return sequencer

This block carries out the two return instructions of a small 8-bit processor core whose instruction cycle is split into four phase strobes (Q1 to Q4). In Q1 of an idle cycle it looks at the 16-bit instruction word. If the word is the interrupt return or the literal return, the block runs a fixed two-cycle sequence. For the interrupt return it re-enables interrupts. For both forms it pops the return-address stack into the program counter. For the literal return it loads the working register with the 8-bit literal.

The block holds the CPU status register. The global interrupt-disable flag sits at bit 4 of that register. The core can write the register and can set the flag when it takes an interrupt. The core supplies the top-of-stack value. The block sends back a pop request, a program-counter load and a working-register write, each with its data. During the second cycle the block raises a flush output, so that the fetch stage throws away the word it prefetched and fetches again from the popped address. The block has no path to the high program-counter latch, so neither instruction can change that latch.

Top module: `ret_seq`

## Requirements
- R1: After synchronous reset the block is idle: pop, pc_ld, wreg_we and flush are 0, pc_nxt and wreg_wd are 0, and sta_q equals 0x10 (interrupt-disable bit 4 set).
- R2: When instr is 0x0005 in Q1 of an idle cycle, bit 4 of sta_q is cleared at the clock edge that ends Q3 of that cycle. The other status bits keep their values.
- R3: For either return form, pop and pc_ld are high for exactly the Q4 clock of the first cycle, and during that clock pc_nxt equals tos. At all other times pc_nxt is 0.
- R4: When instr is 0xB6kk (top byte 0xB6, low byte the literal k) in Q1 of an idle cycle, wreg_we is high in the Q4 clock of the first cycle with wreg_wd equal to k. sta_q is not changed by this instruction.
- R5: The interrupt return never raises wreg_we.
- R6: In the second instruction cycle flush is high in all four phases. pop, pc_ld, wreg_we and the status register are not touched by the sequencer, and a word shown in Q1 of that cycle is ignored, even if it is a return encoding.
- R7: A word that matches neither encoding (for example 0x0004, 0x0105, 0xB700 or 0x8005) causes no pop, no PC load, no register write, no flush and no status change.
- R8: Status update order at a clock edge: a core write (sta_we, sta_wd) is applied first, then the interrupt-return clear of bit 4, then int_take, which sets bit 4.
- R9: A return presented in Q1 of the cycle right after the flush cycle is executed in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one phase per cycle |
| rst | input | 1 | Synchronous active-high reset |
| q_ph | input | 4 | Phase strobes, one-hot, bit 0 is Q1 (2-bit code in the binary variant) |
| instr | input | 16 | Instruction word, held through its instruction cycle |
| tos | input | 16 | Top-of-stack return address |
| int_take | input | 1 | Core accepts an interrupt: sets the disable bit |
| sta_we | input | 1 | Core write strobe for the status register |
| sta_wd | input | 8 | Core write data for the status register |
| pop | output | 1 | Stack pop request, one clock in Q4 |
| pc_ld | output | 1 | Program-counter load strobe |
| pc_nxt | output | 16 | Value to load into the program counter |
| wreg_we | output | 1 | Working-register write strobe |
| wreg_wd | output | 8 | Working-register write data |
| flush | output | 1 | Second cycle of a return: discard the prefetched word |
| sta_q | output | 8 | Status register, bit 4 is the global interrupt disable |

## Verification
A wrong sequencer state shows up at the ports within one instruction cycle. Leaving the idle state by mistake raises flush or pop on a word that matches neither encoding. A missed step to the flush state gives a second pop, or no flush in the following Q1. A phase error moves the clearing of the disable bit, or the pop, into the wrong clock. The bench compares every output on every clock, so such a fault is seen in the clock where it first appears. A bad latched literal shows on wreg_wd in the Q4 clock of the same instruction.

// File: rtl/ret_pkg.sv
package ret_pkg;
   typedef enum logic [1:0] {
      RS_IDLE = 2'd0,
      RS_EXEC = 2'd1,
      RS_NOP  = 2'd2
   } ret_state_e;

   typedef enum logic {
      RK_RFI = 1'b0,
      RK_RLW = 1'b1
   } ret_kind_e;

   typedef struct packed {
      logic p1;
      logic p2;
      logic p3;
      logic p4;
   } phase_t;
endpackage

// File: rtl/ret_phase_dec.sv
module ret_phase_dec
   import ret_pkg::*;
#(
   parameter int PH_BIN = 0,
   localparam int PHW = (PH_BIN != 0) ? 2 : 4
) (
   input  logic [PHW-1:0] q_ph,
   output phase_t         ph
);
   generate
      if (PH_BIN == 0) begin : g_onehot
         assign ph.p1 = q_ph[0];
         assign ph.p2 = q_ph[1];
         assign ph.p3 = q_ph[2];
         assign ph.p4 = q_ph[3];
      end else begin : g_binary
         assign ph.p1 = (q_ph == 2'd0);
         assign ph.p2 = (q_ph == 2'd1);
         assign ph.p3 = (q_ph == 2'd2);
         assign ph.p4 = (q_ph == 2'd3);
      end
   endgenerate
endmodule

// File: rtl/ret_decode.sv
module ret_decode #(
   parameter int IW = 16,
   parameter int DW = 8,
   parameter logic [IW-1:0] OPC_RFI = 16'h0005,
   parameter logic [IW-DW-1:0] OPC_RLW = 8'hB6
) (
   input  logic [IW-1:0] instr,
   output logic          hit_rfi,
   output logic          hit_rlw,
   output logic [DW-1:0] lit
);
   generate
      if (IW <= DW) begin : g_bad_width
         $error("ret_decode: instruction must be wider than literal");
      end
   endgenerate

   assign hit_rfi = (instr == OPC_RFI);
   assign hit_rlw = (instr[IW-1:DW] == OPC_RLW);
   assign lit     = instr[DW-1:0];
endmodule

// File: rtl/ret_fsm.sv
module ret_fsm
   import ret_pkg::*;
#(
   parameter int PCW = 16,
   parameter int DW  = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  phase_t         ph,
   input  logic           hit_rfi,
   input  logic           hit_rlw,
   input  logic [DW-1:0]  lit,
   input  logic [PCW-1:0] tos,
   output logic           pop,
   output logic           pc_ld,
   output logic [PCW-1:0] pc_nxt,
   output logic           wreg_we,
   output logic [DW-1:0]  wreg_wd,
   output logic           flush,
   output logic           gdis_clr
);
   ret_state_e    state;
   ret_kind_e     kind;
   logic [DW-1:0] lit_q;
   logic          in_exec;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= RS_IDLE;
         kind  <= RK_RFI;
         lit_q <= '0;
      end else begin
         case (state)
            RS_IDLE: begin
               if (ph.p1 && (hit_rfi || hit_rlw)) begin
                  state <= RS_EXEC;
                  kind  <= hit_rlw ? RK_RLW : RK_RFI;
               end
            end
            RS_EXEC: begin
               if (ph.p2 && (kind == RK_RLW)) lit_q <= lit;
               if (ph.p4) state <= RS_NOP;
            end
            RS_NOP: begin
               if (ph.p4) state <= RS_IDLE;
            end
            default: state <= RS_IDLE;
         endcase
      end
   end

   assign in_exec  = (state == RS_EXEC);
   assign pop      = in_exec && ph.p4;
   assign pc_ld    = pop;
   assign pc_nxt   = pop ? tos : '0;
   assign wreg_we  = pop && (kind == RK_RLW);
   assign wreg_wd  = wreg_we ? lit_q : '0;
   assign flush    = (state == RS_NOP);
   assign gdis_clr = in_exec && ph.p3 && (kind == RK_RFI);
endmodule

// File: rtl/ret_status.sv
module ret_status #(
   parameter int STA_W    = 8,
   parameter int GDIS_BIT = 4,
   parameter logic [STA_W-1:0] RST_STA = 8'h10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [STA_W-1:0] wd,
   input  logic             clr,
   input  logic             set,
   output logic [STA_W-1:0] sta_q
);
   logic [STA_W-1:0] nxt;

   generate
      if (GDIS_BIT >= STA_W) begin : g_bad_bit
         $error("ret_status: disable bit outside status register");
      end
      if (RST_STA[GDIS_BIT] != 1'b1) begin : g_bad_rst
         $error("ret_status: reset value must disable interrupts");
      end
   endgenerate

   always_comb begin
      nxt = we ? wd : sta_q;
      if (clr) nxt[GDIS_BIT] = 1'b0;
      if (set) nxt[GDIS_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) sta_q <= RST_STA;
      else     sta_q <= nxt;
   end
endmodule

// File: rtl/ret_seq.sv
module ret_seq
   import ret_pkg::*;
#(
   parameter int IW       = 16,
   parameter int DW       = 8,
   parameter int PCW      = 16,
   parameter int STA_W    = 8,
   parameter int GDIS_BIT = 4,
   parameter int PH_BIN   = 0,
   parameter logic [STA_W-1:0] RST_STA = 8'h10,
   parameter logic [IW-1:0]    OPC_RFI = 16'h0005,
   parameter logic [IW-DW-1:0] OPC_RLW = 8'hB6,
   localparam int PHW = (PH_BIN != 0) ? 2 : 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PHW-1:0]   q_ph,
   input  logic [IW-1:0]    instr,
   input  logic [PCW-1:0]   tos,
   input  logic             int_take,
   input  logic             sta_we,
   input  logic [STA_W-1:0] sta_wd,
   output logic             pop,
   output logic             pc_ld,
   output logic [PCW-1:0]   pc_nxt,
   output logic             wreg_we,
   output logic [DW-1:0]    wreg_wd,
   output logic             flush,
   output logic [STA_W-1:0] sta_q
);
   generate
      if (DW < 1 || PCW < 1) begin : g_bad_dims
         $error("ret_seq: widths must be positive");
      end
   endgenerate

   phase_t        ph_w;
   logic          ph3_w;
   logic          ph4_w;
   logic          hit_rfi;
   logic          hit_rlw;
   logic [DW-1:0] lit_w;
   logic          gdis_clr;

   ret_phase_dec #(.PH_BIN(PH_BIN)) u_ph (
      .q_ph (q_ph),
      .ph   (ph_w)
   );

   assign ph3_w = ph_w.p3;
   assign ph4_w = ph_w.p4;

   ret_decode #(
      .IW(IW), .DW(DW), .OPC_RFI(OPC_RFI), .OPC_RLW(OPC_RLW)
   ) u_dec (
      .instr   (instr),
      .hit_rfi (hit_rfi),
      .hit_rlw (hit_rlw),
      .lit     (lit_w)
   );

   ret_fsm #(.PCW(PCW), .DW(DW)) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .ph       (ph_w),
      .hit_rfi  (hit_rfi),
      .hit_rlw  (hit_rlw),
      .lit      (lit_w),
      .tos      (tos),
      .pop      (pop),
      .pc_ld    (pc_ld),
      .pc_nxt   (pc_nxt),
      .wreg_we  (wreg_we),
      .wreg_wd  (wreg_wd),
      .flush    (flush),
      .gdis_clr (gdis_clr)
   );

   ret_status #(
      .STA_W(STA_W), .GDIS_BIT(GDIS_BIT), .RST_STA(RST_STA)
   ) u_sta (
      .clk   (clk),
      .rst   (rst),
      .we    (sta_we),
      .wd    (sta_wd),
      .clr   (gdis_clr),
      .set   (int_take),
      .sta_q (sta_q)
   );
endmodule

// File: rtl/ret_seq_chk.sv
module ret_seq_chk #(
   parameter int PCW      = 16,
   parameter int STA_W    = 8,
   parameter int GDIS_BIT = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             ph3,
   input logic             ph4,
   input logic [PCW-1:0]   tos,
   input logic             sta_we,
   input logic             pop,
   input logic             pc_ld,
   input logic [PCW-1:0]   pc_nxt,
   input logic             wreg_we,
   input logic             flush,
   input logic [STA_W-1:0] sta_q
);
   p_pop_in_q4_r3: assert property (@(posedge clk) disable iff (rst)
      pop |-> ph4);

   p_pop_single_r3: assert property (@(posedge clk) disable iff (rst)
      pop |=> !pop);

   p_pc_from_tos_r3: assert property (@(posedge clk) disable iff (rst)
      pc_ld |-> (pc_nxt == tos) && pop);

   p_wreg_with_pop_r4: assert property (@(posedge clk) disable iff (rst)
      wreg_we |-> pop);

   p_flush_follows_r6: assert property (@(posedge clk) disable iff (rst)
      pop |=> flush);

   p_quiet_in_flush_r6: assert property (@(posedge clk) disable iff (rst)
      flush |-> !pop && !wreg_we);

   p_gdis_clear_q3_r2: assert property (@(posedge clk) disable iff (rst)
      ($fell(sta_q[GDIS_BIT]) && !$past(sta_we)) |-> $past(ph3));
endmodule

bind ret_seq ret_seq_chk #(
   .PCW(PCW), .STA_W(STA_W), .GDIS_BIT(GDIS_BIT)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .ph3     (ph3_w),
   .ph4     (ph4_w),
   .tos     (tos),
   .sta_we  (sta_we),
   .pop     (pop),
   .pc_ld   (pc_ld),
   .pc_nxt  (pc_nxt),
   .wreg_we (wreg_we),
   .flush   (flush),
   .sta_q   (sta_q)
);

// File: tb/sim_ret_seq.sv
`timescale 1ns/1ps
module sim_ret_seq;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  q_ph = 4'b0001;
   logic [15:0] instr = '0;
   logic [15:0] tos = '0;
   logic        int_take = 1'b0;
   logic        sta_we = 1'b0;
   logic [7:0]  sta_wd = '0;
   logic        pop, pc_ld, wreg_we, flush;
   logic [15:0] pc_nxt;
   logic [7:0]  wreg_wd, sta_q;

   always #5 clk = ~clk;

   ret_seq u0 (
      .clk(clk), .rst(rst), .q_ph(q_ph), .instr(instr), .tos(tos),
      .int_take(int_take), .sta_we(sta_we), .sta_wd(sta_wd),
      .pop(pop), .pc_ld(pc_ld), .pc_nxt(pc_nxt), .wreg_we(wreg_we),
      .wreg_wd(wreg_wd), .flush(flush), .sta_q(sta_q)
   );

   int n_chk = 0;
   int n_bad = 0;
   int ph = 0;
   int cyc = 0;
   string tag = "R1";

   // behavioural reference: 0 idle, 1 first cycle, 2 flush cycle
   int       m_st = 0;
   bit       m_lw = 0;
   bit [7:0] m_lit = 0;
   bit [7:0] m_sta = 8'h10;
   int       n_pop_seen = 0;

   task automatic chk(input string what, input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s %s act=%0h exp=%0h", tag, rq, what, act, exp);
      end
   endtask

   task automatic tick(input logic [15:0] iw, input logic [15:0] tv,
                       input logic it, input logic we, input logic [7:0] wd);
      bit e_pop, e_wr;
      @(negedge clk);
      q_ph = 4'b0001 << ph;
      instr = iw; tos = tv; int_take = it; sta_we = we; sta_wd = wd;
      #1;
      if (!rst) begin
         e_pop = (m_st == 1) && (ph == 3);
         e_wr  = e_pop && m_lw;
         chk("pop",     "R3", pop,     e_pop);
         chk("pc_ld",   "R3", pc_ld,   e_pop);
         chk("pc_nxt",  "R3", pc_nxt,  e_pop ? tv : 0);
         chk("wreg_we", "R4 R5", wreg_we, e_wr);
         chk("wreg_wd", "R4", wreg_wd, e_wr ? m_lit : 0);
         chk("flush",   "R6", flush,   m_st == 2);
         chk("sta_q",   "R2 R8", sta_q, m_sta);
         if (pop) n_pop_seen++;
      end
      @(posedge clk);
      if (rst) begin
         m_st = 0; m_sta = 8'h10;
      end else begin
         if (we) m_sta = wd;
         if (m_st == 1 && ph == 2 && !m_lw) m_sta[4] = 1'b0;
         if (it) m_sta[4] = 1'b1;
         case (m_st)
            0: if (ph == 0) begin
                  if (iw == 16'h0005) begin m_st = 1; m_lw = 0; end
                  else if (iw[15:8] == 8'hB6) begin m_st = 1; m_lw = 1; m_lit = iw[7:0]; end
               end
            1: if (ph == 3) m_st = 2;
            default: if (ph == 3) m_st = 0;
         endcase
      end
      ph = (ph + 1) % 4;
   endtask

   // one instruction cycle; tos differs per phase so only the Q4 value is valid
   task automatic icycle(input logic [15:0] iw, input logic [15:0] base);
      for (int i = 0; i < 4; i++) tick(iw, base ^ (16'h0101 * i), 1'b0, 1'b0, 8'h00);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int p0;
      for (int i = 0; i < 8; i++) tick(16'h0000, 16'h0000, 1'b0, 1'b0, 8'h00);
      rst = 1'b0;
      tag = "R1";
      icycle(16'h0000, 16'h1111);
      chk("sta_q after reset", "R1", sta_q, 8'h10);

      // core write with disable bit set, then interrupt return
      tag = "R8";
      tick(16'h0000, 0, 1'b0, 1'b1, 8'h5A);
      tick(16'h0000, 0, 1'b0, 1'b0, 8'h00);
      tick(16'h0000, 0, 1'b0, 1'b0, 8'h00);
      tick(16'h0000, 0, 1'b0, 1'b0, 8'h00);
      tag = "R2";
      p0 = n_pop_seen;
      icycle(16'h0005, 16'h1234);
      tag = "R6";
      icycle(16'h0005, 16'h4321);
      chk("sta after interrupt return", "R2", sta_q, 8'h4A);
      chk("pop count interrupt return", "R6", n_pop_seen - p0, 1);

      tag = "R8";
      tick(16'h0000, 0, 1'b1, 1'b0, 8'h00);
      tick(16'h0000, 0, 1'b0, 1'b0, 8'h00);
      chk("int_take sets bit 4", "R8", sta_q, 8'h5A);
      tick(16'h0000, 0, 1'b1, 1'b1, 8'h03);
      tick(16'h0000, 0, 1'b0, 1'b0, 8'h00);
      chk("int_take over core write", "R8", sta_q, 8'h13);

      tag = "R4";
      icycle(16'hB6A7, 16'hBEEF);
      tag = "R6";
      icycle(16'hB611, 16'h0F0F);
      chk("sta after literal return", "R4", sta_q, 8'h13);

      tag = "R7";
      p0 = n_pop_seen;
      icycle(16'h0004, 16'h2222);
      icycle(16'hB700, 16'h3333);
      icycle(16'h0105, 16'h4444);
      icycle(16'h8005, 16'h5555);
      chk("pops on non-matching words", "R7", n_pop_seen - p0, 0);

      tag = "R9";
      p0 = n_pop_seen;
      icycle(16'hB600, 16'hA5A5);
      icycle(16'h0000, 16'h0000);
      icycle(16'h0005, 16'h5A5A);
      icycle(16'hB6FF, 16'h7777);
      icycle(16'hB6FF, 16'h8888);
      icycle(16'h0000, 16'h0000);
      chk("back-to-back pops", "R9", n_pop_seen - p0, 3);
      chk("sta after back-to-back", "R9", sta_q, 8'h03);

      tag = "R5";
      tick(16'h0000, 0, 1'b0, 1'b1, 8'hFF);
      tick(16'h0000, 0, 1'b0, 1'b0, 8'h00);
      tick(16'h0000, 0, 1'b0, 1'b0, 8'h00);
      tick(16'h0000, 0, 1'b0, 1'b0, 8'h00);
      icycle(16'h0005, 16'hFFFF);
      icycle(16'h0000, 16'h0000);
      chk("sta other bits kept", "R5", sta_q, 8'hEF);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule